// File: doc/BRIEF.md
# Line Refresh DMA Burst Fetcher

This block feeds a display with line data taken straight from DRAM. When a line begins, it takes the bus from the CPU in short bursts. In each burst it reads eight consecutive bytes, packs them into one 64-bit word and pushes that word into a downstream FIFO. A line is ten bursts, which is 80 bytes. The time a line takes is fixed. The host sets the frame rate by how far apart it places the line-start strobes.

Each burst is two runs of four reads. A run opens with a 5-tick random-access read, and its other three reads use the 4-tick page-mode cycle. One burst therefore occupies the bus for 34 ticks. These bursts are the only DRAM activity the block starts, and they take the place of a separate refresh cycle.

The line base address needs only 4-byte alignment. A disable input is sampled when a line is accepted. Between bursts the CPU gets the bus back for a fixed gap, or for longer while the FIFO is short of room.

Top module: `vid_line_fetch`

## Requirements
- R1: After reset, `cpu_halt`, `mem_rd` and `fifo_push` are low and `fifo_data` is zero.
- R2: Each read holds `mem_rd` high with a constant `mem_addr`. A random-access read (`mem_page`=0) lasts 5 cycles and a page-mode read (`mem_page`=1) lasts 4 cycles.
- R3: A burst makes 8 reads at consecutive addresses. The 1st and 5th reads have `mem_page`=0 and an address with bits [1:0]=00. The other six have `mem_page`=1. This gives the pattern 5,4,4,4,5,4,4,4 and 34 access cycles.
- R4: `cpu_halt` rises one cycle before the first read of a burst and falls in the cycle after the last read, so it stays high for 35 cycles.
- R5: In the cycle in which `cpu_halt` falls, `fifo_push` pulses for one cycle. `fifo_data` bits [8k+7:8k] then hold the byte read at burst address + k, for k = 0..7. `fifo_push` is not high at any other time.
- R6: A line accepted at `line_start` produces exactly 10 bursts. They cover addresses base..base+79 in ascending order, with `base_addr` bits [1:0] treated as zero.
- R7: Within a line, with `fifo_room` held high, `cpu_halt` stays low for exactly GAP_TICKS+1 cycles (4 by default) between bursts. The first burst's halt rises two cycles after the `line_start` cycle.
- R8: A burst begins only if `fifo_room` was high in the cycle before `cpu_halt` rises. While `fifo_room` is low, no new burst starts.
- R9: If `dma_off` is high when a `line_start` is accepted, that line makes no reads. Changing `dma_off` during a line does not change the line.
- R10: A `line_start` that arrives while a line still has bursts to run or in flight is ignored.
- R11: `mem_rd` is never high while `cpu_halt` is low. No read, refresh or otherwise, happens outside a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle strobe that begins a display line |
| base_addr | input | ADDR_W | Byte address of the line; the low two bits are ignored |
| dma_off | input | 1 | When high at line acceptance, the line is skipped |
| mem_addr | output | ADDR_W | DRAM byte address of the current read |
| mem_rd | output | 1 | Read strobe, high for the whole access |
| mem_page | output | 1 | High when the current read uses page-mode timing |
| mem_rdata | input | 8 | Read data, captured on the final cycle of each access |
| cpu_halt | output | 1 | Request that holds the CPU off the bus |
| fifo_room | input | 1 | High when the FIFO can take 8 more bytes |
| fifo_push | output | 1 | One-cycle write strobe to the FIFO |
| fifo_data | output | 64 | Packed burst bytes, first byte in the low lane |

## Verification
A tick counter that drifts inside the sequencer shows up at once as a read of the wrong length on `mem_rd`. It also stretches or shortens the 35-cycle halt window within the same burst. An address pointer or byte lane that is corrupted only appears when the burst ends, as a `fifo_data` word that does not match the memory model. A line counter that is off by one shows up either as an eleventh halt or as a missing one, and it also makes the next `line_start` be accepted or rejected wrongly. The stimulus mixes random bases, FIFO back-pressure and spacing with directed disable, overlap and misalignment cases, so that each of these faults is hit.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_ACC  = 2'd2
  } seq_state_t;

  // Duration of one DRAM read in ticks.
  function automatic int access_ticks(input logic page, input int rand_t, input int page_t);
    return page ? page_t : rand_t;
  endfunction

  // Bus ticks consumed by a full burst of runs, each opened by a random access.
  function automatic int burst_bus_ticks(input int runs, input int run_len,
                                         input int rand_t, input int page_t);
    return runs * (rand_t + (run_len - 1) * page_t);
  endfunction

endpackage

// File: rtl/vdma_burst_seq.sv
module vdma_burst_seq #(
  parameter int ADDR_W     = 16,
  parameter int RUN_LEN    = 4,
  parameter int RUNS       = 2,
  parameter int RAND_TICKS = 5,
  parameter int PAGE_TICKS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ADDR_W-1:0]            start_addr,
  output logic                         busy,
  output logic                         burst_done,
  output logic                         cap_en,
  output logic [$clog2(RUN_LEN*RUNS)-1:0] cap_idx,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic                         mem_rd,
  output logic                         mem_page,
  output logic                         cpu_halt
);
  import vdma_pkg::*;

  localparam int BYTES    = RUN_LEN * RUNS;
  localparam int IDX_W    = $clog2(BYTES);
  localparam int RUN_W    = $clog2(RUN_LEN);
  localparam int MAX_T    = (RAND_TICKS > PAGE_TICKS) ? RAND_TICKS : PAGE_TICKS;
  localparam int TICK_W   = $clog2(MAX_T);
  localparam int BUS_T    = burst_bus_ticks(RUNS, RUN_LEN, RAND_TICKS, PAGE_TICKS);

  seq_state_t          state;
  logic [IDX_W-1:0]    acc_idx;
  logic [TICK_W-1:0]   tick;
  logic [ADDR_W-1:0]   base_q;
  logic                cur_page;
  logic                last_tick;
  int                  acc_len;

  assign cur_page   = (acc_idx[RUN_W-1:0] != '0);
  assign acc_len    = access_ticks(cur_page, RAND_TICKS, PAGE_TICKS);
  assign last_tick  = (state == SEQ_ACC) && (tick == TICK_W'(acc_len - 1));
  assign burst_done = last_tick && (acc_idx == IDX_W'(BYTES - 1));
  assign cap_en     = last_tick;
  assign cap_idx    = acc_idx;
  assign mem_rd     = (state == SEQ_ACC);
  assign mem_page   = mem_rd && cur_page;
  assign mem_addr   = base_q + ADDR_W'(acc_idx);
  assign cpu_halt   = (state != SEQ_IDLE);
  assign busy       = cpu_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      acc_idx <= '0;
      tick    <= '0;
      base_q  <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (start) begin
          base_q <= start_addr;
          state  <= SEQ_LEAD;
        end
        SEQ_LEAD: begin
          state   <= SEQ_ACC;
          acc_idx <= '0;
          tick    <= '0;
        end
        SEQ_ACC: begin
          if (last_tick) begin
            tick <= '0;
            if (burst_done) state <= SEQ_IDLE;
            else            acc_idx <= acc_idx + 1'b1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // Independent observers of the bus: access length and halt span.
  logic              prev_rd;
  logic              prev_page;
  logic [ADDR_W-1:0] prev_addr;
  logic [7:0]        hold_cnt;
  logic [7:0]        halt_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd   <= 1'b0;
      prev_page <= 1'b0;
      prev_addr <= '0;
      hold_cnt  <= '0;
      halt_cnt  <= '0;
    end else begin
      prev_rd   <= mem_rd;
      prev_page <= mem_page;
      prev_addr <= mem_addr;
      if (!mem_rd)                                hold_cnt <= '0;
      else if (prev_rd && mem_addr == prev_addr)  hold_cnt <= hold_cnt + 8'd1;
      else                                        hold_cnt <= 8'd1;
      halt_cnt <= cpu_halt ? halt_cnt + 8'd1 : 8'd0;
    end
  end

  assert_access_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_rd && (!mem_rd || mem_addr != prev_addr)) |->
      (int'(hold_cnt) == (prev_page ? PAGE_TICKS : RAND_TICKS)));

  assert_run_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_page) |-> (mem_addr[RUN_W-1:0] == '0));

  assert_halt_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_halt) |=> (mem_rd && !mem_page));

  assert_halt_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_halt) |-> (int'(halt_cnt) == BUS_T + 1));

endmodule

// File: rtl/vdma_line_ctl.sv
module vdma_line_ctl #(
  parameter int ADDR_W    = 16,
  parameter int BURSTS    = 10,
  parameter int BYTES     = 8,
  parameter int ALIGN_W   = 2,
  parameter int GAP_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              dma_off,
  input  logic              fifo_room,
  input  logic              busy,
  input  logic              burst_done,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr
);
  localparam int LEFT_W = $clog2(BURSTS + 1);
  localparam int GAP_W  = $clog2(GAP_TICKS + 2);

  logic [LEFT_W-1:0] left;
  logic [GAP_W-1:0]  gap_cnt;
  logic [ADDR_W-1:0] ptr;
  logic              line_idle;
  logic              accept;

  assign line_idle  = (left == '0) && !busy;
  assign accept     = line_start && line_idle && !dma_off;
  assign start      = (left != '0) && !busy && (gap_cnt == '0) && fifo_room;
  assign start_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left    <= '0;
      gap_cnt <= '0;
      ptr     <= '0;
    end else if (accept) begin
      left    <= LEFT_W'(BURSTS);
      gap_cnt <= '0;
      ptr     <= {base_addr[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end else begin
      if (start) begin
        left <= left - 1'b1;
        ptr  <= ptr + ADDR_W'(BYTES);
      end
      if (burst_done)          gap_cnt <= GAP_W'(GAP_TICKS);
      else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && (left != '0)) |=> (left <= $past(left)));

endmodule

// File: rtl/vdma_pack.sv
module vdma_pack #(
  parameter int BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic [$clog2(BYTES)-1:0] cap_idx,
  input  logic [7:0]               rdata,
  output logic                     fifo_push,
  output logic [BYTES*8-1:0]       fifo_data
);
  localparam int IDX_W = $clog2(BYTES);

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  fifo_data[i*8 +: 8] <= '0;
      else if (cap_en && cap_idx == IDX_W'(i))     fifo_data[i*8 +: 8] <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_push <= 1'b0;
    else        fifo_push <= cap_en && (cap_idx == IDX_W'(BYTES - 1));
  end

endmodule

// File: rtl/vid_line_fetch.sv
module vid_line_fetch #(
  parameter int ADDR_W     = 16,
  parameter int RUN_LEN    = 4,
  parameter int RUNS       = 2,
  parameter int BURSTS     = 10,
  parameter int RAND_TICKS = 5,
  parameter int PAGE_TICKS = 4,
  parameter int GAP_TICKS  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_start,
  input  logic [ADDR_W-1:0]         base_addr,
  input  logic                      dma_off,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_rd,
  output logic                      mem_page,
  input  logic [7:0]                mem_rdata,
  output logic                      cpu_halt,
  input  logic                      fifo_room,
  output logic                      fifo_push,
  output logic [RUN_LEN*RUNS*8-1:0] fifo_data
);
  localparam int BYTES   = RUN_LEN * RUNS;
  localparam int IDX_W   = $clog2(BYTES);
  localparam int ALIGN_W = $clog2(RUN_LEN);

  logic              seq_start;
  logic [ADDR_W-1:0] seq_addr;
  logic              seq_busy;
  logic              seq_done;
  logic              cap_en;
  logic [IDX_W-1:0]  cap_idx;

  vdma_line_ctl #(
    .ADDR_W(ADDR_W), .BURSTS(BURSTS), .BYTES(BYTES),
    .ALIGN_W(ALIGN_W), .GAP_TICKS(GAP_TICKS)
  ) u_line (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .base_addr(base_addr),
    .dma_off(dma_off), .fifo_room(fifo_room), .busy(seq_busy),
    .burst_done(seq_done), .start(seq_start), .start_addr(seq_addr)
  );

  vdma_burst_seq #(
    .ADDR_W(ADDR_W), .RUN_LEN(RUN_LEN), .RUNS(RUNS),
    .RAND_TICKS(RAND_TICKS), .PAGE_TICKS(PAGE_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .start_addr(seq_addr),
    .busy(seq_busy), .burst_done(seq_done), .cap_en(cap_en), .cap_idx(cap_idx),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_page(mem_page), .cpu_halt(cpu_halt)
  );

  vdma_pack #(.BYTES(BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
    .rdata(mem_rdata), .fifo_push(fifo_push), .fifo_data(fifo_data)
  );

  assert_no_stray_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> cpu_halt);

  assert_room_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_halt) |-> $past(fifo_room));

  assert_push_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_halt) |-> fifo_push);

endmodule

// File: tb/vid_line_fetch_bench.sv
module vid_line_fetch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 3;
  localparam int HALT_SPAN  = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [15:0] base_addr = '0;
  logic        dma_off = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        mem_page;
  logic [7:0]  mem_rdata;
  logic        cpu_halt;
  logic        fifo_room = 1'b1;
  logic        fifo_push;
  logic [63:0] fifo_data;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [63:0] exp_word(input logic [15:0] p);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = mem_byte(p + 16'(k));
    return w;
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  vid_line_fetch u_vid_line_fetch (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .base_addr(base_addr),
    .dma_off(dma_off), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_page(mem_page),
    .mem_rdata(mem_rdata), .cpu_halt(cpu_halt), .fifo_room(fifo_room),
    .fifo_push(fifo_push), .fifo_data(fifo_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor state (bench model of a line)
  logic        prev_rd = 0, prev_page = 0, prev_halt = 0, prev_room = 1;
  logic [15:0] prev_addr = '0;
  logic [15:0] exp_ptr = '0;
  int run_len = 0, acc_in_burst = 0, halt_len = 0, low_len = 0;
  int bursts_in_line = 0, halt_rises = 0, pushes = 0;
  bit line_active = 0, room_dropped = 0, lead_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (line_start && !line_active && !dma_off) begin
        line_active = 1; bursts_in_line = 0; exp_ptr = base_addr & 16'hFFFC;
      end
      if (mem_rd && !cpu_halt) chk(0, "R11", 64'(mem_rd), 0);
      if (lead_seen) begin
        chk(mem_rd && !mem_page, "R4 first access follows lead", 64'({mem_rd, mem_page}), 64'h2);
        lead_seen = 0;
      end
      if (prev_rd && (!mem_rd || mem_addr != prev_addr))
        chk(run_len == (prev_page ? 4 : 5), "R2", 64'(run_len), 64'(prev_page ? 4 : 5));
      if (mem_rd && !(prev_rd && mem_addr == prev_addr)) begin
        chk(mem_page == ((acc_in_burst % 4) != 0), "R3 page flag", 64'(mem_page), 64'((acc_in_burst % 4) != 0));
        chk(mem_addr == exp_ptr + 16'(acc_in_burst), "R3 address", 64'(mem_addr), 64'(exp_ptr + 16'(acc_in_burst)));
        acc_in_burst++;
        run_len = 1;
      end else if (mem_rd) begin
        run_len++;
      end
      if (cpu_halt && !prev_halt) begin
        halt_rises++;
        chk(prev_room, "R8 room before start", 64'(prev_room), 1);
        chk(!mem_rd, "R4 lead cycle", 64'(mem_rd), 0);
        if (bursts_in_line > 0 && !room_dropped)
          chk(low_len == GAP + 1, "R7 gap", 64'(low_len), 64'(GAP + 1));
        halt_len = 1; acc_in_burst = 0; lead_seen = 1;
      end else if (cpu_halt) begin
        halt_len++;
      end
      if (!cpu_halt && prev_halt) begin
        chk(halt_len == HALT_SPAN, "R4 halt span", 64'(halt_len), HALT_SPAN);
        chk(acc_in_burst == 8, "R3 reads per burst", 64'(acc_in_burst), 8);
        chk(fifo_push, "R5 push", 64'(fifo_push), 1);
        chk(fifo_data == exp_word(exp_ptr), "R5 data", fifo_data, exp_word(exp_ptr));
        exp_ptr = exp_ptr + 16'd8;
        bursts_in_line++;
        if (bursts_in_line >= 10) line_active = 0;
        low_len = 1; room_dropped = !fifo_room;
      end else if (!cpu_halt) begin
        low_len++;
        if (!fifo_room) room_dropped = 1;
        if (fifo_push) chk(0, "R5 stray push", 1, 0);
      end
      if (fifo_push) pushes++;
      prev_rd = mem_rd; prev_addr = mem_addr; prev_page = mem_page;
      prev_halt = cpu_halt; prev_room = fifo_room;
    end
  end

  task automatic cyc(input bit rnd);
    @(posedge clk); #1;
    line_start = 0;
    if (rnd) fifo_room = ($urandom % 4) != 0;
  endtask

  task automatic pulse_line(input logic [15:0] b);
    @(posedge clk); #1;
    base_addr = b; line_start = 1;
  endtask

  task automatic wait_idle(input bit rnd, input string req);
    int n = 0;
    cyc(rnd);
    while (line_active && n < 20000) begin cyc(rnd); n++; end
    fifo_room = 1;
    repeat (4) cyc(0);
    chk(!line_active && bursts_in_line == 10, req, 64'(bursts_in_line), 10);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected below 150000", wd);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r0, p0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) cyc(0);
    // R1 reset state
    chk(!cpu_halt && !mem_rd && !fifo_push && fifo_data == 0, "R1 reset", 64'({cpu_halt, mem_rd, fifo_push}), 0);

    // R6 aligned line, R7 timing from line start
    pulse_line(16'h0100);
    cyc(0);
    chk(!cpu_halt, "R7 no halt one cycle after strobe", 64'(cpu_halt), 0);
    cyc(0);
    chk(cpu_halt, "R7 halt two cycles after strobe", 64'(cpu_halt), 1);
    wait_idle(0, "R6 ten bursts");

    // R6 misaligned base is rounded down
    pulse_line(16'h1233);
    wait_idle(0, "R6 misaligned base");

    // R9 disabled line: no reads
    dma_off = 1;
    r0 = halt_rises;
    pulse_line(16'h0400);
    repeat (400) cyc(0);
    chk(halt_rises == r0, "R9 disabled line", 64'(halt_rises - r0), 0);
    dma_off = 0;

    // R9 disable mid-line has no effect
    pulse_line(16'h0800);
    repeat (60) cyc(0);
    dma_off = 1;
    wait_idle(0, "R9 mid-line disable ignored");
    dma_off = 0;

    // R10 second strobe during a line is ignored
    p0 = pushes;
    pulse_line(16'h2000);
    repeat (70) cyc(0);
    pulse_line(16'h3000);
    wait_idle(0, "R10 line completes");
    chk(pushes - p0 == 10, "R10 only one line", 64'(pushes - p0), 10);

    // R8 back-pressure holds off new bursts
    pulse_line(16'h0C00);
    repeat (50) cyc(0);
    fifo_room = 0;
    cyc(0);
    r0 = halt_rises;
    repeat (150) begin @(posedge clk); #1; end
    chk(halt_rises == r0, "R8 no start without room", 64'(halt_rises - r0), 0);
    fifo_room = 1;
    wait_idle(0, "R8 line resumes");

    // Random lines with random back-pressure and spacing
    for (int i = 0; i < 15; i++) begin
      pulse_line(16'($urandom));
      wait_idle(1, "R6 random line");
      repeat ($urandom % 20) cyc(0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule